// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block forms the second ALU operand of a 32-bit RISC datapath in a single combinational pass. It accepts one of two sources. The first is a compact immediate: an 8-bit constant plus a 4-bit rotate field, which it expands to a full 32-bit word. The second is a register value with a shift kind and a shift amount. Alongside the operand it delivers a shifter carry, which the flag logic downstream may use in place of the ALU carry.

The shift amount for the register path comes from a 5-bit field in the instruction or from the low byte of a second register. One encoding, a rotate with an instruction amount of zero, is given a special meaning: a one-bit rotate through the incoming carry. Register-supplied amounts may be zero or reach past the word width, and the block defines the result and the carry for every such amount.

Internally a decoder first turns the source selection, kind and amount into one normalized operation: pass, left, logical right, arithmetic right, rotate or rotate-through-carry. A shifter core carries out that operation, and a separate rotator expands the immediate. The top selects between the immediate and the register results.

Top module: `operand_shifter`

## Requirements
- R1: With `use_imm`=1, `operand` equals `imm_field[7:0]` zero-extended to 32 bits and rotated right by 2×`imm_field[11:8]` bit positions, so the rotation is always even (0 to 30).
- R2: In immediate mode `carry_out` equals `carry_in` when `imm_field[11:8]` is 0. Otherwise it equals bit 31 of `operand`, which is the last bit the rotation moved.
- R3: In register mode `shift_kind` is encoded 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. With `amt_from_reg`=0 the amount is `shamt_imm` (1 to 31). For every kind `carry_out` is the last bit shifted out of `reg_value`.
- R4: An arithmetic right shift fills every vacated upper bit with `reg_value[31]`.
- R5: A rotate right re-inserts the bits leaving bit 0 at bit 31, so no bit is lost.
- R6: With `amt_from_reg`=0, `shift_kind`=2'b11 and `shamt_imm`=0, the block rotates through the carry by one bit: `operand` = {`carry_in`, `reg_value[31:1]`} and `carry_out` = `reg_value[0]`.
- R7: A zero amount leaves the value unchanged: `operand` = `reg_value` and `carry_out` = `carry_in`. This covers `shamt_imm`=0 for kinds 2'b00, 2'b01 and 2'b10, and `shamt_reg`=0 for all four kinds. A register amount of zero never selects the rotate-through-carry case.
- R8: With `amt_from_reg`=1 the amount is `shamt_reg` (0 to 255). Amounts 1 to 31 behave as in R3.
- R9: Logical shifts by a register amount of 32 give zero, with `carry_out` equal to `reg_value[0]` for left and `reg_value[31]` for right. Amounts above 32 give zero with `carry_out`=0.
- R10: An arithmetic right shift by a register amount of 32 or more gives 32 copies of `reg_value[31]`, with `carry_out` = `reg_value[31]`.
- R11: A rotate by a register amount of 32 or more rotates by the amount modulo 32. A nonzero multiple of 32 leaves `operand` = `reg_value` with `carry_out` = `reg_value[31]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| use_imm | input | 1 | 1 selects the rotated immediate, 0 the shifted register |
| imm_field | input | 12 | [11:8] rotate count (in units of two bits), [7:0] constant |
| reg_value | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | Shift kind, encoded as in R3 |
| amt_from_reg | input | 1 | 1 takes the amount from `shamt_reg`, 0 from `shamt_imm` |
| shamt_imm | input | 5 | Instruction-encoded shift amount |
| shamt_reg | input | 8 | Low byte of the amount register |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Generated second operand |
| carry_out | output | 1 | Shifter carry |

## Verification
Assertions inside the logic check some properties on every evaluation. Arithmetic shifts keep the sign bit, and rotations keep the population count. Rotate-through-carry places `carry_in` at bit 31 and moves bit 0 to the carry. Zero amounts pass the value and the carry through. Logical shifts beyond 33 bits give zero. The immediate path keeps its constant's bit count, and a zero rotate field leaves the constant and the carry unchanged. The exact bit positions and carries are shown only by the bench's scenarios: each shift kind at mid-range amounts, the edges at 1, 31, 32, 33 and 255, rotate counts of multiples of 32, and every immediate rotate field. These are compared against a bit-serial model.

// File: rtl/operand_shifter_pkg.sv
package operand_shifter_pkg;

    // Shift kind as encoded on the shift_kind port
    typedef enum logic [1:0] {
        KIND_LSL = 2'b00,
        KIND_LSR = 2'b01,
        KIND_ASR = 2'b10,
        KIND_ROR = 2'b11
    } shift_kind_e;

    // Normalized operation handed from the decoder to the core
    typedef enum logic [2:0] {
        OP_PASS,
        OP_LSL,
        OP_LSR,
        OP_ASR,
        OP_ROR,
        OP_RRX
    } shift_op_e;

endpackage

// File: rtl/operand_shifter_decode.sv
module operand_shifter_decode
    import operand_shifter_pkg::*;
#(
    parameter int SHAMT_BITS   = 5,
    parameter int REG_AMT_BITS = 8
) (
    input  logic [1:0]              kind_i,
    input  logic                    from_reg_i,
    input  logic [SHAMT_BITS-1:0]   shamt_imm_i,
    input  logic [REG_AMT_BITS-1:0] shamt_reg_i,
    output shift_op_e               op_o,
    output logic [REG_AMT_BITS-1:0] amt_o
);

    shift_kind_e kind;
    shift_op_e   kind_op;

    assign kind = shift_kind_e'(kind_i);

    always_comb begin
        unique case (kind)
            KIND_LSL: kind_op = OP_LSL;
            KIND_LSR: kind_op = OP_LSR;
            KIND_ASR: kind_op = OP_ASR;
            KIND_ROR: kind_op = OP_ROR;
            default:  kind_op = OP_PASS;
        endcase
    end

    always_comb begin
        if (from_reg_i) begin
            amt_o = shamt_reg_i;
            op_o  = (shamt_reg_i == '0) ? OP_PASS : kind_op;
        end else begin
            amt_o = REG_AMT_BITS'(shamt_imm_i);
            if (shamt_imm_i != '0)
                op_o = kind_op;
            else if (kind == KIND_ROR)
                op_o = OP_RRX;
            else
                op_o = OP_PASS;
        end
    end

    // R6 / R7: a zero amount only ever maps to pass or rotate-through-carry
    always_comb begin
        if (amt_o == '0)
            a_r7_zero_amount_op: assert (op_o == OP_PASS || op_o == OP_RRX);
        if (from_reg_i)
            a_r6_no_rrx_from_reg: assert (op_o != OP_RRX);
    end

endmodule

// File: rtl/operand_shifter_imm.sv
module operand_shifter_imm #(
    parameter int WIDTH    = 32,
    parameter int IMM_BITS = 8,
    parameter int ROT_BITS = 4
) (
    input  logic [IMM_BITS-1:0] imm_i,
    input  logic [ROT_BITS-1:0] rot_i,
    input  logic                carry_i,
    output logic [WIDTH-1:0]    value_o,
    output logic                carry_o
);

    localparam int RAMT_BITS = ROT_BITS + 1;

    logic [WIDTH-1:0]     ext;
    logic [RAMT_BITS-1:0] ramt;

    assign ext  = WIDTH'(imm_i);
    assign ramt = {rot_i, 1'b0};

    always_comb begin
        value_o = (ext >> ramt) | (ext << (WIDTH - int'(ramt)));
        carry_o = (rot_i == '0) ? carry_i : value_o[WIDTH-1];

        // R1: rotation neither creates nor drops set bits
        a_r1_imm_bitcount: assert ($countones(value_o) == $countones(imm_i));
        // R2: zero rotate keeps the constant and the incoming carry
        if (rot_i == '0)
            a_r2_imm_no_rotate: assert (value_o == ext && carry_o == carry_i);
    end

endmodule

// File: rtl/operand_shifter_core.sv
module operand_shifter_core
    import operand_shifter_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter int REG_AMT_BITS = 8
) (
    input  shift_op_e               op_i,
    input  logic [REG_AMT_BITS-1:0] amt_i,
    input  logic [WIDTH-1:0]        value_i,
    input  logic                    carry_i,
    output logic [WIDTH-1:0]        value_o,
    output logic                    carry_o
);

    localparam int SEL_BITS = $clog2(WIDTH);
    localparam logic [REG_AMT_BITS-1:0] LOG_LIMIT = REG_AMT_BITS'(WIDTH + 1);
    localparam logic [REG_AMT_BITS-1:0] ASR_LIMIT = REG_AMT_BITS'(WIDTH);

    logic [REG_AMT_BITS-1:0] log_amt;
    logic [REG_AMT_BITS-1:0] asr_amt;
    logic [WIDTH:0]          lsl_wide;
    logic [WIDTH:0]          lsr_wide;
    logic signed [WIDTH:0]   asr_wide;
    logic [SEL_BITS:0][WIDTH-1:0] rot_stage;

    // Amounts past the word saturate: one extra position flushes the carry too
    assign log_amt  = (amt_i > LOG_LIMIT) ? LOG_LIMIT : amt_i;
    assign asr_amt  = (amt_i > ASR_LIMIT) ? ASR_LIMIT : amt_i;
    assign lsl_wide = {1'b0, value_i} << log_amt;
    assign lsr_wide = {value_i, 1'b0} >> log_amt;
    assign asr_wide = $signed({value_i, 1'b0}) >>> asr_amt;

    // Logarithmic rotator, one stage per amount bit (amount taken modulo WIDTH)
    assign rot_stage[0] = value_i;
    for (genvar k = 0; k < SEL_BITS; k++) begin : g_rot
        localparam int STEP = 2 ** k;
        assign rot_stage[k+1] = amt_i[k]
            ? {rot_stage[k][STEP-1:0], rot_stage[k][WIDTH-1:STEP]}
            : rot_stage[k];
    end

    always_comb begin
        unique case (op_i)
            OP_LSL: begin
                value_o = lsl_wide[WIDTH-1:0];
                carry_o = lsl_wide[WIDTH];
            end
            OP_LSR: begin
                value_o = lsr_wide[WIDTH:1];
                carry_o = lsr_wide[0];
            end
            OP_ASR: begin
                value_o = asr_wide[WIDTH:1];
                carry_o = asr_wide[0];
            end
            OP_ROR: begin
                value_o = rot_stage[SEL_BITS];
                carry_o = rot_stage[SEL_BITS][WIDTH-1];
            end
            OP_RRX: begin
                value_o = {carry_i, value_i[WIDTH-1:1]};
                carry_o = value_i[0];
            end
            default: begin
                value_o = value_i;
                carry_o = carry_i;
            end
        endcase

        if (op_i == OP_ASR)
            a_r4_asr_keeps_sign: assert (value_o[WIDTH-1] == value_i[WIDTH-1]);
        if (op_i == OP_ROR)
            a_r5_ror_bitcount: assert ($countones(value_o) == $countones(value_i));
        if (op_i == OP_RRX)
            a_r6_rrx_carry_path: assert (value_o[WIDTH-1] == carry_i && carry_o == value_i[0]);
        if (op_i == OP_PASS)
            a_r7_pass_through: assert (value_o == value_i && carry_o == carry_i);
        if ((op_i == OP_LSL || op_i == OP_LSR) && amt_i > LOG_LIMIT)
            a_r9_logical_flush: assert (value_o == '0 && carry_o == 1'b0);
    end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
    import operand_shifter_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter int IMM_BITS     = 8,
    parameter int ROT_BITS     = 4,
    parameter int SHAMT_BITS   = 5,
    parameter int REG_AMT_BITS = 8,
    localparam int IMMF_BITS   = IMM_BITS + ROT_BITS
) (
    input  logic                    use_imm,
    input  logic [IMMF_BITS-1:0]    imm_field,
    input  logic [WIDTH-1:0]        reg_value,
    input  logic [1:0]              shift_kind,
    input  logic                    amt_from_reg,
    input  logic [SHAMT_BITS-1:0]   shamt_imm,
    input  logic [REG_AMT_BITS-1:0] shamt_reg,
    input  logic                    carry_in,
    output logic [WIDTH-1:0]        operand,
    output logic                    carry_out
);

    shift_op_e               dec_op;
    logic [REG_AMT_BITS-1:0] dec_amt;
    logic [WIDTH-1:0]        imm_value;
    logic                    imm_carry;
    logic [WIDTH-1:0]        reg_result;
    logic                    reg_carry;

    operand_shifter_decode #(
        .SHAMT_BITS  (SHAMT_BITS),
        .REG_AMT_BITS(REG_AMT_BITS)
    ) u_decode (
        .kind_i     (shift_kind),
        .from_reg_i (amt_from_reg),
        .shamt_imm_i(shamt_imm),
        .shamt_reg_i(shamt_reg),
        .op_o       (dec_op),
        .amt_o      (dec_amt)
    );

    operand_shifter_imm #(
        .WIDTH   (WIDTH),
        .IMM_BITS(IMM_BITS),
        .ROT_BITS(ROT_BITS)
    ) u_imm (
        .imm_i  (imm_field[IMM_BITS-1:0]),
        .rot_i  (imm_field[IMMF_BITS-1:IMM_BITS]),
        .carry_i(carry_in),
        .value_o(imm_value),
        .carry_o(imm_carry)
    );

    operand_shifter_core #(
        .WIDTH       (WIDTH),
        .REG_AMT_BITS(REG_AMT_BITS)
    ) u_core (
        .op_i   (dec_op),
        .amt_i  (dec_amt),
        .value_i(reg_value),
        .carry_i(carry_in),
        .value_o(reg_result),
        .carry_o(reg_carry)
    );

    always_comb begin
        operand   = use_imm ? imm_value : reg_result;
        carry_out = use_imm ? imm_carry : reg_carry;

        // R7: a zero register amount passes value and carry, across decode and core
        if (!use_imm && amt_from_reg && shamt_reg == '0)
            a_r7_reg_zero_pass: assert (operand == reg_value && carry_out == carry_in);
    end

endmodule

// File: tb/operand_shifter_test.sv
`timescale 1ns/1ps
module operand_shifter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        use_imm;
    logic [11:0] imm_field;
    logic [31:0] reg_value;
    logic [1:0]  shift_kind;
    logic        amt_from_reg;
    logic [4:0]  shamt_imm;
    logic [7:0]  shamt_reg;
    logic        carry_in;
    logic [31:0] operand;
    logic        carry_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    operand_shifter uut (
        .use_imm     (use_imm),
        .imm_field   (imm_field),
        .reg_value   (reg_value),
        .shift_kind  (shift_kind),
        .amt_from_reg(amt_from_reg),
        .shamt_imm   (shamt_imm),
        .shamt_reg   (shamt_reg),
        .carry_in    (carry_in),
        .operand     (operand),
        .carry_out   (carry_out)
    );

    // Bit-serial reference: one position per step, carry follows the leaving bit
    function automatic logic [32:0] model(
        input logic        m_imm,
        input logic [11:0] m_immf,
        input logic [31:0] m_val,
        input logic [1:0]  m_kind,
        input logic        m_from_reg,
        input logic [4:0]  m_si,
        input logic [7:0]  m_sr,
        input logic        m_cin
    );
        logic [31:0] x;
        logic        c;
        int          n;
        c = m_cin;
        if (m_imm) begin
            x = {24'd0, m_immf[7:0]};
            n = 2 * int'(m_immf[11:8]);
            for (int i = 0; i < n; i++) begin
                c = x[0];
                x = {x[0], x[31:1]};
            end
            return {c, x};
        end
        x = m_val;
        n = m_from_reg ? int'(m_sr) : int'(m_si);
        if (n == 0) begin
            if (!m_from_reg && m_kind == 2'b11) return {m_val[0], m_cin, m_val[31:1]};
            return {m_cin, m_val};
        end
        for (int i = 0; i < n; i++) begin
            case (m_kind)
                2'b00: begin c = x[31]; x = {x[30:0], 1'b0}; end
                2'b01: begin c = x[0];  x = {1'b0, x[31:1]}; end
                2'b10: begin c = x[0];  x = {x[31], x[31:1]}; end
                default: begin c = x[0]; x = {x[0], x[31:1]}; end
            endcase
        end
        return {c, x};
    endfunction

    task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got carry=%0b operand=%08h, expected carry=%0b operand=%08h",
                     tag, got[32], got[31:0], exp[32], exp[31:0]);
        end
    endtask

    // Drive on the falling edge, compare a quarter period later
    task automatic apply(input string tag, input logic i_imm, input logic [11:0] i_immf,
                         input logic [31:0] i_val, input logic [1:0] i_kind,
                         input logic i_from_reg, input logic [4:0] i_si,
                         input logic [7:0] i_sr, input logic i_cin);
        @(negedge clk);
        use_imm = i_imm; imm_field = i_immf; reg_value = i_val; shift_kind = i_kind;
        amt_from_reg = i_from_reg; shamt_imm = i_si; shamt_reg = i_sr; carry_in = i_cin;
        #2;
        check(tag, {carry_out, operand},
              model(i_imm, i_immf, i_val, i_kind, i_from_reg, i_si, i_sr, i_cin));
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        use_imm = 1'b1; imm_field = '0; reg_value = '0; shift_kind = '0;
        amt_from_reg = 1'b0; shamt_imm = '0; shamt_reg = '0; carry_in = 1'b0;
        #2;
        check("R1 idle after reset", {carry_out, operand}, 33'd0);
    endtask

    task automatic t_immediate;
        for (int r = 0; r < 16; r++) begin
            apply("R1 R2 immediate rotate c0", 1'b1, {4'(r), 8'hA5}, 32'h0, 2'b00, 1'b0, 5'd0, 8'd0, 1'b0);
            apply("R1 R2 immediate rotate c1", 1'b1, {4'(r), 8'h81}, 32'h0, 2'b00, 1'b0, 5'd0, 8'd0, 1'b1);
        end
        // Explicit values: 0xFF rotated by 8 lands in the top byte, carry from bit 31
        apply("R1 immediate 0xFF ror 8", 1'b1, 12'h4FF, 32'h0, 2'b00, 1'b0, 5'd0, 8'd0, 1'b0);
        check("R2 immediate top byte", {carry_out, operand}, {1'b1, 32'hFF00_0000});
    endtask

    task automatic t_imm_amounts;
        logic [31:0] pats [3] = '{32'h8000_0001, 32'h1234_5678, 32'hF0F0_0F0F};
        int amts [4] = '{1, 7, 16, 31};
        for (int p = 0; p < 3; p++)
            for (int a = 0; a < 4; a++) begin
                apply("R3 lsl field amount", 1'b0, 12'h0, pats[p], 2'b00, 1'b0, 5'(amts[a]), 8'd0, 1'b0);
                apply("R3 lsr field amount", 1'b0, 12'h0, pats[p], 2'b01, 1'b0, 5'(amts[a]), 8'd0, 1'b1);
                apply("R4 asr field amount", 1'b0, 12'h0, pats[p], 2'b10, 1'b0, 5'(amts[a]), 8'd0, 1'b0);
                apply("R5 ror field amount", 1'b0, 12'h0, pats[p], 2'b11, 1'b0, 5'(amts[a]), 8'd0, 1'b1);
            end
        apply("R4 asr fills ones", 1'b0, 12'h0, 32'h8000_0000, 2'b10, 1'b0, 5'd4, 8'd0, 1'b0);
        check("R4 asr explicit", {carry_out, operand}, {1'b0, 32'hF800_0000});
        apply("R5 ror explicit", 1'b0, 12'h0, 32'h0000_00F1, 2'b11, 1'b0, 5'd4, 8'd0, 1'b0);
        check("R5 ror wraps low nibble", {carry_out, operand}, {1'b0, 32'h1000_000F});
    endtask

    task automatic t_zero_field;
        apply("R6 rrx carry 1", 1'b0, 12'h0, 32'h0000_0003, 2'b11, 1'b0, 5'd0, 8'd0, 1'b1);
        check("R6 rrx explicit", {carry_out, operand}, {1'b1, 32'h8000_0001});
        apply("R6 rrx carry 0", 1'b0, 12'h0, 32'hFFFF_FFFE, 2'b11, 1'b0, 5'd0, 8'd0, 1'b0);
        for (int k = 0; k < 3; k++)
            apply("R7 zero field pass", 1'b0, 12'h0, 32'hDEAD_BEEF, 2'(k), 1'b0, 5'd0, 8'd0, 1'b1);
        for (int k = 0; k < 4; k++)
            apply("R7 zero register pass", 1'b0, 12'h0, 32'h8765_4321, 2'(k), 1'b1, 5'd9, 8'd0, 1'b1);
        apply("R7 reg zero ror keeps carry", 1'b0, 12'h0, 32'h0000_0001, 2'b11, 1'b1, 5'd0, 8'd0, 1'b0);
        check("R7 no rrx from register", {carry_out, operand}, {1'b0, 32'h0000_0001});
    endtask

    task automatic t_reg_amounts;
        logic [31:0] pats [2] = '{32'h8000_0001, 32'h7ACE_5F03};
        int amts [9] = '{1, 5, 31, 32, 33, 64, 100, 224, 255};
        for (int p = 0; p < 2; p++)
            for (int a = 0; a < 9; a++) begin
                apply("R8 R9 lsl register", 1'b0, 12'h0, pats[p], 2'b00, 1'b1, 5'd3, 8'(amts[a]), 1'b1);
                apply("R8 R9 lsr register", 1'b0, 12'h0, pats[p], 2'b01, 1'b1, 5'd3, 8'(amts[a]), 1'b0);
                apply("R10 asr register", 1'b0, 12'h0, pats[p], 2'b10, 1'b1, 5'd3, 8'(amts[a]), 1'b0);
                apply("R11 ror register", 1'b0, 12'h0, pats[p], 2'b11, 1'b1, 5'd3, 8'(amts[a]), 1'b0);
            end
        apply("R9 lsl by 32", 1'b0, 12'h0, 32'h0000_0001, 2'b00, 1'b1, 5'd0, 8'd32, 1'b0);
        check("R9 lsl 32 carry bit0", {carry_out, operand}, {1'b1, 32'h0});
        apply("R9 lsr by 40", 1'b0, 12'h0, 32'hFFFF_FFFF, 2'b01, 1'b1, 5'd0, 8'd40, 1'b1);
        check("R9 lsr 40 flush", {carry_out, operand}, {1'b0, 32'h0});
        apply("R10 asr by 200", 1'b0, 12'h0, 32'h8000_0000, 2'b10, 1'b1, 5'd0, 8'd200, 1'b0);
        check("R10 asr saturates", {carry_out, operand}, {1'b1, 32'hFFFF_FFFF});
        apply("R11 ror by 64", 1'b0, 12'h0, 32'h8000_1234, 2'b11, 1'b1, 5'd0, 8'd64, 1'b0);
        check("R11 ror multiple of 32", {carry_out, operand}, {1'b1, 32'h8000_1234});
        apply("R11 ror by 36", 1'b0, 12'h0, 32'h0000_0018, 2'b11, 1'b1, 5'd0, 8'd36, 1'b0);
        check("R11 ror modulo", {carry_out, operand}, {1'b1, 32'h8000_0001});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_immediate();
        t_imm_amounts();
        t_zero_field();
        t_reg_amounts();
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule